// File: doc/BRIEF.md
# Core Clock Doze Divider

This block slows the processor core without touching the peripherals. Both run from one system clock. The block produces two clock-enable strobes from it. The peripheral strobe is high on every cycle. The core strobe is high on every cycle while doze is off. While doze is on, the core strobe is thinned to one pulse per 2^n system cycles, where n is a 3-bit ratio code. Both strobes come from the same clock, so a peripheral that talks to the core needs no synchronizer. Serial links and other rate-sensitive peripherals keep their timing while the core crawls.

Software turns doze on and off through a write strobe and a data bit. It can also allow an automatic exit. When the return-on-interrupt control is high, an interrupt event clears the doze state and the core goes back to full speed. When that control is low, interrupt events leave doze alone. If the ratio code changes, the divider restarts. The first core pulse under the new code then comes one whole new period later.

Top module: `core_doze_divider`

## Requirements
- R1: In reset (synchronous, active high) and in the first cycle after it, `doze_active` is 0 and `core_ce` is 1. The stored doze state clears to 0.
- R2: While `doze_active` is 0, `core_ce` is 1 on every cycle, whatever the ratio code.
- R3: While doze is active with ratio code n held steady, `core_ce` is high on exactly one cycle in every 2^n. Counting the first cycle after enable or restart as cycle 0, it is high on cycle j when j mod 2^n equals 2^n−1.
- R4: A change of `ratio_sel` restarts the divider. The cycle after the change counts as cycle 0 under the new code.
- R5: `periph_ce` is 1 on every cycle, in reset, in doze and out of doze.
- R6: When `roi_en` and `irq_evt` are both 1, `doze_active` is 0 from the next cycle, and `core_ce` is 1 on every cycle from then on.
- R7: When `roi_en` is 0, `irq_evt` changes neither `doze_active` nor the `core_ce` pattern.
- R8: When an interrupt clear (`roi_en` and `irq_evt` both 1) and a write of 1 (`doze_wr` = 1, `doze_wdata` = 1) fall in the same cycle, the clear wins and `doze_active` becomes 0.
- R9: Ratio code 0 in doze gives a 1:1 ratio: `core_ce` stays high on every cycle.
- R10: A cycle with `doze_wr` = 1 and no interrupt clear loads `doze_wdata` into the doze state. The new value shows on `doze_active` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| doze_wr | input | 1 | Write strobe for the doze-enable state |
| doze_wdata | input | 1 | Value written to the doze-enable state |
| ratio_sel | input | 3 | Ratio code n, giving core rate = system rate / 2^n |
| roi_en | input | 1 | Allows an interrupt to end doze |
| irq_evt | input | 1 | Interrupt event pulse |
| core_ce | output | 1 | Core clock enable |
| periph_ce | output | 1 | Peripheral clock enable, always high |
| doze_active | output | 1 | Doze-enable state |

## Verification
Every ratio code from 0 to 7 is run with doze on, for three full periods. Each cycle's `core_ce` is checked against the modulo formula. This separates a correct mask from one that is off by a power of two or misaligned by a cycle. A second pattern changes the ratio part-way through a period. This shows whether the divider restarts or carries its old count forward. Interrupt events are then applied with the return-on-interrupt control low, with it high, and with it high during a same-cycle write of 1. These runs separate "interrupt ignored", "interrupt clears" and "clear beats write".

// File: rtl/doze_pkg.sv
package doze_pkg;
    localparam int RATIO_W = 3;
    localparam int CNT_W   = (1 << RATIO_W) - 1;

    typedef logic [RATIO_W-1:0] ratio_t;
    typedef logic [CNT_W-1:0]   cnt_t;

    typedef struct packed {
        logic wr;
        logic wdata;
        logic roi;
        logic irq;
    } doze_req_t;

    function automatic logic hw_clear(doze_req_t r);
        return r.roi & r.irq;
    endfunction
endpackage

// File: rtl/doze_ctrl.sv
module doze_ctrl
    import doze_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  doze_req_t req,
    output logic      doze_en
);
    always_ff @(posedge clk) begin
        if (rst)
            doze_en <= 1'b0;
        else if (hw_clear(req))
            doze_en <= 1'b0;
        else if (req.wr)
            doze_en <= req.wdata;
    end

    // R6
    irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (req.roi && req.irq) |=> !doze_en);

    // R7
    irq_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (!req.roi && !req.wr) |=> (doze_en == $past(doze_en)));

    // R8
    clear_prio_chk: assert property (@(posedge clk) disable iff (rst)
        (req.roi && req.irq && req.wr && req.wdata) |=> !doze_en);

    // R10
    write_load_chk: assert property (@(posedge clk) disable iff (rst)
        (req.wr && !(req.roi && req.irq)) |=> (doze_en == $past(req.wdata)));
endmodule

// File: rtl/doze_div.sv
module doze_div
    import doze_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   doze_en,
    input  ratio_t ratio_in,
    output logic   core_ce
);
    ratio_t ratio_q;
    cnt_t   cnt;
    cnt_t   mask;
    logic   period_end;
    logic   restart;

    for (genvar i = 0; i < CNT_W; i++) begin : g_mask
        assign mask[i] = (int'(ratio_q) > i);
    end

    assign restart    = !doze_en || (ratio_in != ratio_q);
    assign period_end = ((cnt & mask) == mask);
    assign core_ce    = !doze_en || period_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            ratio_q <= '0;
            cnt     <= '0;
        end else begin
            ratio_q <= ratio_in;
            if (restart)
                cnt <= '0;
            else
                cnt <= cnt + 1'b1;
        end
    end

    // R4
    ratio_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (doze_en && (ratio_in != ratio_q) && (ratio_in != '0)) |=> (!core_ce || !doze_en));

    // R3
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (doze_en && period_end && (ratio_q != '0) && (ratio_in == ratio_q)) |=> (!core_ce || !doze_en));

    // R2
    full_rate_chk: assert property (@(posedge clk) disable iff (rst)
        (!doze_en) |-> core_ce);
endmodule

// File: rtl/core_doze_divider.sv
module core_doze_divider
    import doze_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               doze_wr,
    input  logic               doze_wdata,
    input  logic [RATIO_W-1:0] ratio_sel,
    input  logic               roi_en,
    input  logic               irq_evt,
    output logic               core_ce,
    output logic               periph_ce,
    output logic               doze_active
);
    doze_req_t req;
    logic      doze_en;

    assign req = '{wr: doze_wr, wdata: doze_wdata, roi: roi_en, irq: irq_evt};

    doze_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .doze_en (doze_en)
    );

    doze_div u_div (
        .clk      (clk),
        .rst      (rst),
        .doze_en  (doze_en),
        .ratio_in (ratio_sel),
        .core_ce  (core_ce)
    );

    assign periph_ce   = 1'b1;
    assign doze_active = doze_en;
endmodule

// File: tb/core_doze_divider_test.sv
module core_doze_divider_test;
    logic       clk = 1'b0;
    logic       rst;
    logic       doze_wr, doze_wdata, roi_en, irq_evt;
    logic [2:0] ratio_sel;
    logic       core_ce, periph_ce, doze_active;
    int         checks = 0;
    int         errors = 0;
    bit         done   = 1'b0;

    always #5 clk = ~clk;

    core_doze_divider uut (
        .clk(clk), .rst(rst), .doze_wr(doze_wr), .doze_wdata(doze_wdata),
        .ratio_sel(ratio_sel), .roi_en(roi_en), .irq_evt(irq_evt),
        .core_ce(core_ce), .periph_ce(periph_ce), .doze_active(doze_active)
    );

    task automatic check(input logic got, input logic exp, input string req);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic write_en(input logic v);
        doze_wr = 1'b1; doze_wdata = v;
        step();
        doze_wr = 1'b0; doze_wdata = 1'b0;
    endtask

    // R3 / R9: full sweep of one ratio code, starting doze from off
    task automatic run_ratio(input int n);
        int p;
        p = 1 << n;
        write_en(1'b0);
        ratio_sel = 3'(n);
        step();
        write_en(1'b1);
        for (int j = 0; j < 3 * p; j++) begin
            check(core_ce, ((j % p) == p - 1), (n == 0) ? "R9" : "R3");
            check(periph_ce, 1'b1, "R5");
            step();
        end
    endtask

    initial begin
        rst = 1'b1; doze_wr = 1'b0; doze_wdata = 1'b0;
        roi_en = 1'b0; irq_evt = 1'b0; ratio_sel = 3'd0;
        step(); step();
        // R1: in reset
        check(doze_active, 1'b0, "R1");
        check(core_ce, 1'b1, "R1");
        check(periph_ce, 1'b1, "R5");
        rst = 1'b0;
        step();
        check(doze_active, 1'b0, "R1");
        check(core_ce, 1'b1, "R1");

        // R2: doze off, nonzero ratio -> full rate
        ratio_sel = 3'd5;
        for (int k = 0; k < 10; k++) begin
            step();
            check(core_ce, 1'b1, "R2");
        end

        for (int n = 0; n < 8; n++) run_ratio(n);

        // R4: change ratio mid-period (ratio 2 -> 3)
        write_en(1'b0);
        ratio_sel = 3'd2;
        step();
        write_en(1'b1);
        for (int j = 0; j < 5; j++) step();
        ratio_sel = 3'd3;
        step();
        for (int j = 0; j < 16; j++) begin
            check(core_ce, ((j % 8) == 7), "R4");
            step();
        end

        // R7: interrupt with roi off is ignored; pattern continues (j=16..)
        roi_en = 1'b0; irq_evt = 1'b1;
        for (int j = 16; j < 32; j++) begin
            check(core_ce, ((j % 8) == 7), "R7");
            check(doze_active, 1'b1, "R7");
            step();
        end
        irq_evt = 1'b0;

        // R6: interrupt with roi on clears doze
        roi_en = 1'b1; irq_evt = 1'b1;
        step();
        irq_evt = 1'b0;
        check(doze_active, 1'b0, "R6");
        for (int k = 0; k < 10; k++) begin
            check(core_ce, 1'b1, "R6");
            step();
        end

        // R8: clear beats same-cycle write of 1
        irq_evt = 1'b1; doze_wr = 1'b1; doze_wdata = 1'b1;
        step();
        irq_evt = 1'b0; doze_wr = 1'b0; doze_wdata = 1'b0;
        check(doze_active, 1'b0, "R8");
        check(core_ce, 1'b1, "R8");
        roi_en = 1'b0;

        // R10: write 1 then write 0
        write_en(1'b1);
        check(doze_active, 1'b1, "R10");
        check(core_ce, 1'b0, "R10");
        write_en(1'b0);
        check(doze_active, 1'b0, "R10");
        check(core_ce, 1'b1, "R10");

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule